// File: doc/BRIEF.md
# Capture/Compare Timer Status Flags

This block is one channel of a 16-bit up-counting timer. It has four general registers, named A to D. Each one works either as a compare register or as a capture register. Every hardware event latches into a sticky status flag:

- a counter wrap,
- a compare hit,
- a capture.

Each status flag, ANDed with its enable, drives an interrupt request.

Software reads the status register and then writes 0 to the flags it wants to drop. A flag is cleared only if the last read returned it as 1. A transfer engine can also drop a general-register flag when it services that flag's interrupt, unless its keep-flag input is high.

The CPU reaches the block through a plain register bus. The bus has a 3-bit address, a write strobe and a read strobe. Read data is combinational from the address.

Address map:

| Address | Register |
|---|---|
| 0 | Status |
| 1 | Counter |
| 2 | General register A |
| 3 | General register B |
| 4 | General register C |
| 5 | General register D |

Top module: `ccflag_timer`

## Requirements
- R1: After reset, the counter and all general registers are 0. The status register reads 16'h00C0 and every interrupt request is low.
- R2: Status bit layout:
  - bits 7 and 6 always read 1;
  - bit 5 always reads 0;
  - bit 4 is the wrap flag;
  - bits 3, 2, 1 and 0 are the flags of general registers D, C, B and A;
  - the upper 8 bits of the read data are 0.
- R3: When `cnt_en` is high and the counter holds 16'hFFFF, the next edge takes the counter to 0 and sets status bit 4 on that same edge.
- R4: General register i is in compare mode when `gr_mode[i]` = 0. In that mode, its flag sets on the counting edge that makes the counter equal to the register.
- R5: General register i is in capture mode when `gr_mode[i]` = 1. A rising edge on `cap_pin[i]` passes through two synchronizer flops. The register then takes the counter value and its flag sets on the third clock edge after the pin rises.
- R6: A write of 0 to a flag that was not returned as 1 by a status read since the last status write leaves the flag set.
- R7: A status read that returns 1 arms that flag. A later write of 0 to it clears the flag. Writing 1 leaves the flag set. Any status write disarms all flags, so a second write of 0 does not clear.
- R8: A pulse on `xfer_ack[i]` clears general flag i when `xfer_keep` is 0. The pulse has no effect when `xfer_keep` is 1.
- R9: When a set event and a clear act on a flag in the same cycle, the flag ends up set.
- R10: `irq[k]` is high exactly when status flag k (bit k of the 5-bit flag field) is set and `irq_en[k]` is high.
- R11: A compare match is ignored for a register in capture mode. A capture pin edge is ignored for a register in compare mode, and that register's value is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter increments on each edge while high |
| gr_mode | input | 4 | Per general register: 1 = capture, 0 = compare |
| cap_pin | input | 4 | Asynchronous capture inputs, A in bit 0 |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flags on status reads) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| xfer_ack | input | 4 | Transfer engine service acknowledge per general flag |
| xfer_keep | input | 1 | When high, acknowledges leave flags set |
| irq_en | input | 5 | Interrupt enables, same bit order as the flags |
| irq | output | 5 | Interrupt requests |

## Verification
A flag that stays set when it should not, or rises spuriously, shows at once: it appears in the next status read and on `irq` on the edge after the fault. A lost or wrong arm bit stays hidden until software tries to clear. The bench therefore uses read/write sequences in which the arm state is the only thing that decides whether a clear happens. A capture path that is off by a stage is caught by sampling the status both one cycle before and exactly on the cycle the flag is due.

// File: rtl/ccflag_pkg.sv
package ccflag_pkg;
  localparam int unsigned GR_N    = 4;
  localparam int unsigned FLG_N   = GR_N + 1;
  localparam int unsigned WRAP_IX = GR_N;
  localparam int unsigned ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_STAT    = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT     = 3'd1;
  localparam logic [ADDR_W-1:0] A_GR_BASE = 3'd2;

  // Status image: two high reserved ones, one reserved zero, then the flags.
  function automatic logic [7:0] stat_image(input logic [FLG_N-1:0] f);
    return {2'b11, 1'b0, f};
  endfunction

  // Next flag state: clearing first, then setting, so a set always survives.
  function automatic logic [FLG_N-1:0] flag_next(input logic [FLG_N-1:0] cur,
                                                 input logic [FLG_N-1:0] set,
                                                 input logic [FLG_N-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/ccflag_counter.sv
module ccflag_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_inc_o,
  output logic             step_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign step_o    = tick & ~load;
  assign cnt_inc_o = cnt_q + CNT_W'(1);
  assign wrap_o    = step_o & (&cnt_q);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load)    cnt_q <= load_val;
    else if (step_o)  cnt_q <= cnt_inc_o;
  end
endmodule

// File: rtl/ccflag_capsync.sv
module ccflag_capsync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  localparam int unsigned SH_W = SYNC_STAGES + 1;
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], pin_i};
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/ccflag_flagreg.sv
module ccflag_flagreg
  import ccflag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLG_N-1:0] set_i,
  input  logic [GR_N-1:0]  ack_i,
  input  logic             ack_keep_i,
  input  logic             rd_stat_i,
  input  logic             wr_stat_i,
  input  logic [FLG_N-1:0] wbits_i,
  output logic [FLG_N-1:0] flag_o,
  output logic [FLG_N-1:0] arm_o,
  output logic [FLG_N-1:0] sw_clr_o,
  output logic [GR_N-1:0]  ack_clr_o
);
  logic [FLG_N-1:0] flag_q, arm_q, clr_all;

  assign sw_clr_o  = {FLG_N{wr_stat_i}} & arm_q & ~wbits_i;
  assign ack_clr_o = ack_i & {GR_N{~ack_keep_i}};
  assign clr_all   = sw_clr_o | {1'b0, ack_clr_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= flag_next(flag_q, set_i, clr_all);
      if (wr_stat_i)      arm_q <= '0;
      else if (rd_stat_i) arm_q <= arm_q | flag_q;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;
endmodule

// File: rtl/ccflag_timer.sv
module ccflag_timer
  import ccflag_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [GR_N-1:0]   gr_mode,
  input  logic [GR_N-1:0]   cap_pin,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [GR_N-1:0]   xfer_ack,
  input  logic              xfer_keep,
  input  logic [FLG_N-1:0]  irq_en,
  output logic [FLG_N-1:0]  irq
);
  logic [CNT_W-1:0]            cnt_q, cnt_inc;
  logic                        step, ovf_evt;
  logic [GR_N-1:0][CNT_W-1:0]  gr_q;
  logic [GR_N-1:0]             rise, cmp_evt, cap_evt;
  logic [FLG_N-1:0]            set_vec, flag_q, arm_q, sw_clr;
  logic [GR_N-1:0]             ack_clr;
  logic                        wr_cnt, wr_stat, rd_stat;

  assign wr_cnt  = bus_wr & (bus_addr == A_CNT);
  assign wr_stat = bus_wr & (bus_addr == A_STAT);
  assign rd_stat = bus_rd & (bus_addr == A_STAT);

  ccflag_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cnt_en), .load(wr_cnt),
    .load_val(bus_wdata), .cnt_o(cnt_q), .cnt_inc_o(cnt_inc),
    .step_o(step), .wrap_o(ovf_evt)
  );

  for (genvar i = 0; i < GR_N; i++) begin : g_gr
    logic wr_gr;
    assign wr_gr = bus_wr & (bus_addr == A_GR_BASE + ADDR_W'(i));

    ccflag_capsync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(cap_pin[i]), .rise_o(rise[i])
    );

    assign cap_evt[i] = rise[i] & gr_mode[i];
    assign cmp_evt[i] = step & ~gr_mode[i] & (cnt_inc == gr_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          gr_q[i] <= '0;
      else if (cap_evt[i]) gr_q[i] <= cnt_q;
      else if (wr_gr)      gr_q[i] <= bus_wdata;
    end
  end

  assign set_vec = {ovf_evt, cmp_evt | cap_evt};

  ccflag_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .ack_i(xfer_ack),
    .ack_keep_i(xfer_keep), .rd_stat_i(rd_stat), .wr_stat_i(wr_stat),
    .wbits_i(bus_wdata[FLG_N-1:0]), .flag_o(flag_q), .arm_o(arm_q),
    .sw_clr_o(sw_clr), .ack_clr_o(ack_clr)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT) bus_rdata = CNT_W'(stat_image(flag_q));
    if (bus_addr == A_CNT)  bus_rdata = cnt_q;
    for (int i = 0; i < GR_N; i++)
      if (bus_addr == A_GR_BASE + ADDR_W'(i)) bus_rdata = gr_q[i];
  end

  assign irq = flag_q & irq_en;
endmodule

// File: rtl/ccflag_checker.sv
module ccflag_checker
  import ccflag_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [CNT_W-1:0]           cnt_q,
  input logic [GR_N-1:0][CNT_W-1:0] gr_q,
  input logic [FLG_N-1:0]           flag_q,
  input logic [FLG_N-1:0]           set_vec,
  input logic [FLG_N-1:0]           sw_clr,
  input logic [GR_N-1:0]            ack_clr,
  input logic [GR_N-1:0]            cap_evt,
  input logic                       ovf_evt,
  input logic [FLG_N-1:0]           irq_en,
  input logic [FLG_N-1:0]           irq
);
  logic [FLG_N-1:0] ack_ext;
  assign ack_ext = {1'b0, ack_clr};

  AST_WRAP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag_q[WRAP_IX]); // R3

  for (genvar k = 0; k < FLG_N; k++) begin : g_flg
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[k] |=> flag_q[k]); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[k] && !sw_clr[k] && !ack_ext[k]) |=> flag_q[k]); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[k] && !set_vec[k]) |=> !flag_q[k]); // R4
    AST_SW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr[k] && !set_vec[k]) |=> !flag_q[k]); // R7
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec[k] && irq_en[k]) ##1 irq_en[k] |-> irq[k]); // R10
  end

  for (genvar j = 0; j < GR_N; j++) begin : g_gr
    AST_CAP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[j] |=> gr_q[j] == $past(cnt_q)); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_clr[j] && !set_vec[j]) |=> !flag_q[j]); // R8
  end
endmodule

bind ccflag_timer ccflag_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .gr_q(gr_q), .flag_q(flag_q),
  .set_vec(set_vec), .sw_clr(sw_clr), .ack_clr(ack_clr), .cap_evt(cap_evt),
  .ovf_evt(ovf_evt), .irq_en(irq_en), .irq(irq)
);

// File: tb/ccflag_timer_test.sv
module ccflag_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [3:0]  gr_mode = 4'h0;
  logic [3:0]  cap_pin = 4'h0;
  logic [2:0]  bus_addr = 3'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [3:0]  xfer_ack = 4'h0;
  logic        xfer_keep = 1'b0;
  logic [4:0]  irq_en = 5'h0;
  logic [4:0]  irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ccflag_timer uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gr_mode(gr_mode),
    .cap_pin(cap_pin), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_ack(xfer_ack),
    .xfer_keep(xfer_keep), .irq_en(irq_en), .irq(irq)
  );

  // Expected status image from the flag field: reserved 1,1,0 on top.
  function automatic logic [15:0] stat_exp(input logic [4:0] f);
    return {8'h00, 3'b110, f};
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic clear_all();
    logic [15:0] d;
    bus_read(3'd0, d);
    bus_write(3'd0, 16'h0000);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    bus_read(3'd0, d); check("R1 status after reset", d, 16'h00C0);
    bus_read(3'd1, d); check("R1 counter after reset", d, 16'h0000);
    check("R1 irq after reset", {11'h0, irq}, 16'h0);
  endtask

  task automatic t_wrap_and_clear();
    logic [15:0] d;
    bus_write(3'd1, 16'hFFFE);
    run_ticks(1);
    bus_read(3'd1, d); check("R3 counter at FFFF", d, 16'hFFFF);
    run_ticks(1);
    bus_read(3'd1, d); check("R3 counter wrapped", d, 16'h0000);
    // wrap sets bit4; all GRs are 0 in compare mode so they match too
    bus_read(3'd0, d); check("R3 R2 wrap flag set", d, stat_exp(5'h1F));
    bus_write(3'd0, 16'h00FF);          // writing 1s: no clear, disarms
    bus_read(3'd0, d); check("R7 write 1 no effect", d, stat_exp(5'h1F));
    bus_write(3'd0, 16'h00FF);          // disarm again
    bus_write(3'd0, 16'h0000);          // not armed: no clear
    bus_read(3'd0, d); check("R6 unarmed write 0 kept", d, stat_exp(5'h1F));
    bus_write(3'd0, 16'h00EF);          // armed: clears bit 4 only
    bus_read(3'd0, d); check("R7 armed clear of bit4", d, stat_exp(5'h0F));
    clear_all();
    bus_read(3'd0, d); check("R7 clear all", d, stat_exp(5'h00));
  endtask

  task automatic t_compare();
    logic [15:0] d;
    gr_mode = 4'b0000;
    irq_en = 5'b00001;
    bus_write(3'd2, 16'd5);
    bus_write(3'd3, 16'd7);
    bus_write(3'd4, 16'd3);
    bus_write(3'd5, 16'h0100);
    bus_write(3'd1, 16'd0);
    run_ticks(3);
    bus_read(3'd0, d); check("R4 compare C at 3", d, stat_exp(5'h04));
    check("R10 irq masked", {11'h0, irq}, 16'h0000);
    run_ticks(2);
    bus_read(3'd0, d); check("R4 compare A at 5", d, stat_exp(5'h05));
    check("R10 irq A enabled", {11'h0, irq}, 16'h0001);
    run_ticks(2);
    bus_read(3'd0, d); check("R4 compare B at 7", d, stat_exp(5'h07));
    irq_en = 5'b00110;
    #1 check("R10 irq with new enables", {11'h0, irq}, 16'h0006);
    irq_en = 5'b00000;
    clear_all();
  endtask

  task automatic t_capture();
    logic [15:0] d;
    gr_mode = 4'b1111;
    bus_write(3'd1, 16'h1234);
    cap_pin[2] = 1'b1;
    repeat (2) @(negedge clk);
    bus_addr = 3'd0; #1 check("R5 no flag before third edge", bus_rdata, stat_exp(5'h00));
    @(negedge clk);
    #1 check("R5 flag on third edge", bus_rdata, stat_exp(5'h04));
    bus_read(3'd4, d); check("R5 captured value", d, 16'h1234);
    bus_write(3'd1, 16'h2222);
    repeat (4) @(negedge clk);
    bus_read(3'd4, d); check("R5 held pin no recapture", d, 16'h1234);
    cap_pin[2] = 1'b0;
    // compare ignored in capture mode
    bus_write(3'd2, 16'h2223);
    run_ticks(1);
    bus_read(3'd0, d); check("R11 capture mode ignores match", d, stat_exp(5'h04));
    // capture pin ignored in compare mode
    gr_mode = 4'b1101;
    cap_pin[1] = 1'b1;
    repeat (5) @(negedge clk);
    cap_pin[1] = 1'b0;
    bus_read(3'd3, d); check("R11 compare mode ignores pin", d, 16'd7);
    bus_read(3'd0, d); check("R11 no flag B from pin", d, stat_exp(5'h04));
  endtask

  task automatic t_xfer_ack();
    logic [15:0] d;
    xfer_keep = 1'b1; xfer_ack = 4'b0100;
    @(negedge clk);
    xfer_ack = 4'b0000;
    bus_read(3'd0, d); check("R8 keep holds flag", d, stat_exp(5'h04));
    xfer_keep = 1'b0; xfer_ack = 4'b0100;
    @(negedge clk);
    xfer_ack = 4'b0000;
    bus_read(3'd0, d); check("R8 ack clears flag", d, stat_exp(5'h00));
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    gr_mode = 4'b1111;
    bus_write(3'd1, 16'hFFFF);
    run_ticks(1);                       // wrap: bit4 set
    bus_write(3'd1, 16'hFFFF);
    bus_read(3'd0, d); check("R3 wrap set for race", d, stat_exp(5'h10));
    // armed write 0 and a new wrap on the same edge
    bus_addr = 3'd0; bus_wdata = 16'h0000; bus_wr = 1'b1; cnt_en = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; cnt_en = 1'b0;
    bus_read(3'd0, d); check("R9 set wins over clear", d, stat_exp(5'h10));
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wrap_and_clear();
    t_compare();
    t_capture();
    t_xfer_ack();
    t_set_wins();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule